// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register core of a general-purpose I/O controller serving 128 pins grouped into four banks of 32. Pin n belongs to bank n>>5 at bit n&31. A simple register bus reaches the block. It has a write strobe, a read strobe, a 12-bit byte address and 32-bit data. Each access takes one cycle. Read data comes back, qualified by a valid flag, in the cycle after the read strobe. The block holds per-bank direction, output latch, rising and falling edge enables and two alternate-function words. It drives each pin's output value and output enable. It also presents the edge enables to a separate edge-detect unit, which owns the edge status bits and the interrupt logic.

The output latch is never written directly. A set register ORs ones into it and a clear register removes them. Reading a pin's level returns the latch for output pins and the sampled pad for input pins. Every level read sends out a single-cycle notify pulse. The status registers of the edge-detect unit appear in this block's map but are only forwarded: the block selects the bank, passes back the status word, and issues a clear strobe with a mask. A small access sequencer records what kind of access finished in the previous cycle. From that record it produces the read-valid, the level notify and the error pulse.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset the direction, output latch, last-set, edge-enable and alternate-function registers are zero, so `pin_drive`, `pin_oe`, `rise_en` and `fall_en` are all zero, and `bus_rvalid`, `lvl_rd_pulse` and `bad_addr_pulse` are low.
- R2: Banks 0 to 2 use a word-spaced window: level at 0x000+4b, direction at 0x00c+4b, set at 0x018+4b, clear at 0x024+4b, rising enable at 0x030+4b, falling enable at 0x03c+4b, status at 0x048+4b. Bank 3 uses the same offsets plus 0x100, starting from the bank-0 offset (level 0x100, direction 0x10c, and so on). Direction and edge-enable registers read back what was written. They drive `pin_oe`, `rise_en` and `fall_en` at bits [32b+31:32b].
- R3: A write to a set register ORs the data into that bank's output latch. A read of a set register returns the last value written to it.
- R4: A write to a clear register clears the latch bits where the data is 1. A read of a clear register returns the constant 0x00007A69.
- R5: `pin_oe` equals the direction bits (1 = output), and `pin_drive` equals latch AND direction, so input pins drive 0.
- R6: A level read returns (latch AND direction) OR (`pin_in` AND NOT direction) for its bank. Writes to level registers have no effect.
- R7: The read data and `bus_rvalid` appear in the cycle after the read strobe. A level read also raises `lvl_rd_pulse` in that same cycle for exactly one cycle.
- R8: Byte addresses at or above 0x200 read as zero with no error pulse, and writes to them change nothing.
- R9: An address below 0x200 that hits no register, including an address whose two low bits are not zero, reads as zero. In the cycle after any access to such an address, `bad_addr_pulse` is high for one cycle. Writes to such an address change nothing.
- R10: During an access to a status register, `edge_sel` gives its bank in the same cycle. A read returns `edge_word`. A write raises `edge_clr` in that cycle with `edge_clr_mask` equal to the write data.
- R11: When write and read strobes come in the same cycle, the write takes effect and the read is dropped: no `bus_rvalid` and no `lvl_rd_pulse` follow.
- R12: There are eight alternate-function words. The low word of bank b is at 0x054+8b and the high word at 0x058+8b. They store 32 bits and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| lvl_rd_pulse | output | 1 | One-cycle pulse after a level register read |
| bad_addr_pulse | output | 1 | One-cycle pulse after an access to an unmapped in-range address |
| pin_in | input | 128 | Sampled pad levels |
| pin_drive | output | 128 | Output value per pin |
| pin_oe | output | 128 | Output enable per pin |
| rise_en | output | 128 | Rising-edge detect enable per pin |
| fall_en | output | 128 | Falling-edge detect enable per pin |
| edge_sel | output | 2 | Bank selected for a status access |
| edge_word | input | 32 | Status word of the selected bank |
| edge_clr | output | 1 | Status clear strobe |
| edge_clr_mask | output | 32 | Bits to clear in the selected status word |

## Verification
The sequencer can see a write and a read in the same cycle. The bench provokes this by raising both strobes at once, once on a direction register and once on a level register. It judges the result by seeing no read-valid and no notify pulse afterwards, and by reading back that the written direction took effect. A second overlap is a level read landing while the output latch of the same bank has just been changed by a set or a clear. The bench reads directly after each latch update and expects the merged value to already show the new latch bits on output pins and the pads on input pins.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);

    typedef enum logic [3:0] {
        K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_STAT, K_AFL, K_AFH
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [BANK_W-1:0] bank;
    } dec_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_OK, ST_RD_LEVEL, ST_RD_BAD, ST_WR_OK, ST_WR_BAD
    } st_e;

    // Register group order inside a window; the group index is word/3.
    function automatic kind_e group_kind(input logic [5:0] g);
        case (g)
            6'd0:    return K_LEVEL;
            6'd1:    return K_DIR;
            6'd2:    return K_SET;
            6'd3:    return K_CLR;
            6'd4:    return K_RISE;
            6'd5:    return K_FALL;
            6'd6:    return K_STAT;
            default: return K_NONE;
        endcase
    endfunction

    // Decodes a 9-bit byte offset inside the register window.
    function automatic dec_t decode(input logic [8:0] off);
        dec_t       d;
        logic [5:0] w;
        w      = off[7:2];
        d.kind = K_NONE;
        d.bank = '0;
        if (off[1:0] == 2'b00) begin
            if (!off[8]) begin
                if (w < 6'd21) begin
                    d.kind = group_kind(w / 6'd3);
                    d.bank = BANK_W'(w % 6'd3);
                end else if (w <= 6'd28) begin
                    d.kind = w[0] ? K_AFL : K_AFH;
                    d.bank = BANK_W'((w - 6'd21) >> 1);
                end
            end else if ((w % 6'd3) == 6'd0 && w <= 6'd18) begin
                d.kind = group_kind(w / 6'd3);
                d.bank = BANK_W'(NBANK - 1);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output kind_e             kind,
    output logic [BANK_W-1:0] bank,
    output logic              in_range,
    output logic              unmapped
);
    dec_t dec;

    always_comb begin
        in_range = (addr >> 9) == '0;
        dec      = decode(addr[8:0]);
        kind     = in_range ? dec.kind : K_NONE;
        bank     = dec.bank;
        unmapped = in_range && (dec.kind == K_NONE);
    end
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic rd,
    input  logic is_level,
    input  logic is_bad,
    output logic rvalid,
    output logic lvl_pulse,
    output logic bad_pulse
);
    st_e state, state_nx;

    always_comb begin
        if (wr)
            state_nx = is_bad ? ST_WR_BAD : ST_WR_OK;
        else if (rd && is_bad)
            state_nx = ST_RD_BAD;
        else if (rd && is_level)
            state_nx = ST_RD_LEVEL;
        else if (rd)
            state_nx = ST_RD_OK;
        else
            state_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        rvalid    = 1'b0;
        lvl_pulse = 1'b0;
        bad_pulse = 1'b0;
        unique case (state)
            ST_IDLE, ST_WR_OK: ;
            ST_RD_OK:    rvalid = 1'b1;
            ST_RD_LEVEL: begin rvalid = 1'b1; lvl_pulse = 1'b1; end
            ST_RD_BAD:   begin rvalid = 1'b1; bad_pulse = 1'b1; end
            ST_WR_BAD:   bad_pulse = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_regs_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter logic [31:0] CLR_VAL = 32'h0000_7A69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  kind_e             kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pads,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] drive,
    output logic [DATA_W-1:0] oe,
    output logic [DATA_W-1:0] rise,
    output logic [DATA_W-1:0] fall
);
    logic [DATA_W-1:0] dir_q, lat_q, set_q, rise_q, fall_q, afl_q, afh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            lat_q  <= '0;
            set_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            afl_q  <= '0;
            afh_q  <= '0;
        end else if (we) begin
            case (kind)
                K_DIR:  dir_q  <= wdata;
                K_SET:  begin lat_q <= lat_q | wdata; set_q <= wdata; end
                K_CLR:  lat_q  <= lat_q & ~wdata;
                K_RISE: rise_q <= wdata;
                K_FALL: fall_q <= wdata;
                K_AFL:  afl_q  <= wdata;
                K_AFH:  afh_q  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (kind)
            K_LEVEL: rd_word = (lat_q & dir_q) | (pads & ~dir_q);
            K_DIR:   rd_word = dir_q;
            K_SET:   rd_word = set_q;
            K_CLR:   rd_word = DATA_W'(CLR_VAL);
            K_RISE:  rd_word = rise_q;
            K_FALL:  rd_word = fall_q;
            K_AFL:   rd_word = afl_q;
            K_AFH:   rd_word = afh_q;
            default: rd_word = '0;
        endcase
    end

    assign drive = lat_q & dir_q;
    assign oe    = dir_q;
    assign rise  = rise_q;
    assign fall  = fall_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_regs_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] CLR_RD_VAL = 32'h0000_7A69,
    localparam int         PINS       = NBANK * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              lvl_rd_pulse,
    output logic              bad_addr_pulse,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_drive,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   rise_en,
    output logic [PINS-1:0]   fall_en,
    output logic [BANK_W-1:0] edge_sel,
    input  logic [DATA_W-1:0] edge_word,
    output logic              edge_clr,
    output logic [DATA_W-1:0] edge_clr_mask
);
    kind_e             kind;
    logic [BANK_W-1:0] bank;
    logic              in_range, unmapped;
    logic [DATA_W-1:0] bank_rd [NBANK];
    logic [DATA_W-1:0] rd_next, rdata_q;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .kind(kind), .bank(bank),
        .in_range(in_range), .unmapped(unmapped)
    );

    gpio_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd),
        .is_level(kind == K_LEVEL), .is_bad(unmapped),
        .rvalid(bus_rvalid), .lvl_pulse(lvl_rd_pulse), .bad_pulse(bad_addr_pulse)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpio_bank #(.DATA_W(DATA_W), .CLR_VAL(CLR_RD_VAL)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .we(bus_wr && bank == BANK_W'(b)),
            .kind(kind), .wdata(bus_wdata),
            .pads(pin_in[b*DATA_W +: DATA_W]),
            .rd_word(bank_rd[b]),
            .drive(pin_drive[b*DATA_W +: DATA_W]),
            .oe(pin_oe[b*DATA_W +: DATA_W]),
            .rise(rise_en[b*DATA_W +: DATA_W]),
            .fall(fall_en[b*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        if (kind == K_NONE)      rd_next = '0;
        else if (kind == K_STAT) rd_next = edge_word;
        else                     rd_next = bank_rd[bank];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 rdata_q <= '0;
        else if (bus_rd && !bus_wr) rdata_q <= rd_next;
    end

    assign bus_rdata     = rdata_q;
    assign edge_sel      = bank;
    assign edge_clr      = bus_wr && (kind == K_STAT);
    assign edge_clr_mask = bus_wdata;
endmodule

// File: rtl/gpio_regs_chk.sv
module gpio_regs_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PINS   = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              lvl_rd_pulse,
    input logic              bad_addr_pulse,
    input logic [PINS-1:0]   pin_drive,
    input logic [PINS-1:0]   pin_oe,
    input logic [PINS-1:0]   rise_en,
    input logic [PINS-1:0]   fall_en,
    input logic              edge_clr
);
    logic far;
    assign far = bus_addr >= ADDR_W'(12'h200);

    assert_read_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> bus_rvalid);

    assert_notify_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_rd_pulse |-> bus_rvalid);

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (!bus_rvalid && !lvl_rd_pulse));

    assert_far_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && far) |=> (bus_rdata == '0 && !bad_addr_pulse));

    assert_far_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && far) |=> ($stable(pin_oe) && $stable(pin_drive)
                             && $stable(rise_en) && $stable(fall_en)));

    assert_clear_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        edge_clr |-> bus_wr);
endmodule

bind gpio_bank_regs gpio_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PINS(PINS)) u_chk (.*);

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_rvalid, lvl_rd_pulse, bad_addr_pulse;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_drive, pin_oe, rise_en, fall_en;
    logic [1:0]   edge_sel;
    logic [31:0]  edge_word = '0;
    logic         edge_clr;
    logic [31:0]  edge_clr_mask;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_bank_regs i_gpio_bank_regs (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic rd, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        cyc(1'b0, 1'b1, a, '0);
        d = bus_rdata;
    endtask

    function automatic logic [11:0] bank_addr(input logic [11:0] base, input int b);
        return (b < 3) ? base + 12'(4 * b) : base + 12'h100;
    endfunction

    task automatic t_reset();
        chk("R1 rvalid", {31'b0, bus_rvalid}, 0);
        chk("R1 pulses", {30'b0, lvl_rd_pulse, bad_addr_pulse}, 0);
        chk("R1 oe", {31'b0, |pin_oe}, 0);
        chk("R1 drive", {31'b0, |pin_drive}, 0);
        chk("R1 edge en", {30'b0, |rise_en, |fall_en}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        for (int b = 0; b < 4; b++) begin
            wr(bank_addr(12'h00c, b), 32'h1100_0000 + 32'(b) * 32'h0101_0101);
            wr(bank_addr(12'h030, b), 32'h2200_0000 + 32'(b));
            wr(bank_addr(12'h03c, b), 32'h3300_0000 + 32'(b));
            wr(12'h054 + 12'(8 * b), 32'hA0A0_0000 + 32'(b));
            wr(12'h058 + 12'(8 * b), 32'hB0B0_0000 + 32'(b));
        end
        for (int b = 0; b < 4; b++) begin
            rd(bank_addr(12'h00c, b), v); chk("R2 dir readback", v, 32'h1100_0000 + 32'(b) * 32'h0101_0101);
            chk("R2 oe slice", pin_oe[b*32 +: 32], 32'h1100_0000 + 32'(b) * 32'h0101_0101);
            rd(bank_addr(12'h030, b), v); chk("R2 rise readback", v, 32'h2200_0000 + 32'(b));
            chk("R2 rise slice", rise_en[b*32 +: 32], 32'h2200_0000 + 32'(b));
            rd(bank_addr(12'h03c, b), v); chk("R2 fall readback", v, 32'h3300_0000 + 32'(b));
            chk("R2 fall slice", fall_en[b*32 +: 32], 32'h3300_0000 + 32'(b));
            rd(12'h054 + 12'(8 * b), v); chk("R12 alt low", v, 32'hA0A0_0000 + 32'(b));
            rd(12'h058 + 12'(8 * b), v); chk("R12 alt high", v, 32'hB0B0_0000 + 32'(b));
        end
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        wr(12'h010, 32'hFFFF_0000);
        wr(12'h01c, 32'h00FF_00FF);
        chk("R5 drive gated", pin_drive[63:32], 32'h00FF_0000);
        rd(12'h000 + 12'h004, v); chk("R6 level after set", v, 32'h00FF_0000);
        rd(12'h01c, v); chk("R3 set readback", v, 32'h00FF_00FF);
        wr(12'h01c, 32'hF000_0000);
        rd(12'h01c, v); chk("R3 set last value", v, 32'hF000_0000);
        chk("R3 set ORs", pin_drive[63:32], 32'hF0FF_0000);
        wr(12'h028, 32'h0F0F_0000);
        chk("R4 clear", pin_drive[63:32], 32'hF0F0_0000);
        rd(12'h028, v); chk("R4 clear read const", v, 32'h0000_7A69);
        wr(12'h010, 32'hFFFF_FFFF);
        chk("R5 dir exposes latch", pin_drive[63:32], 32'hF0F0_00FF);
        chk("R5 oe follows dir", pin_oe[63:32], 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(12'h10c, 32'h0000_FFFF);
        wr(12'h118, 32'h1234_5678);
        pin_in[127:96] = 32'hCAFE_BEEF;
        rd(12'h100, v);
        chk("R6 merged level", v, 32'hCAFE_5678);
        chk("R7 notify on level read", {31'b0, lvl_rd_pulse}, 1);
        chk("R7 valid on level read", {31'b0, bus_rvalid}, 1);
        wr(12'h100, 32'h0000_0000);
        chk("R7 notify one cycle", {31'b0, lvl_rd_pulse}, 0);
        rd(12'h100, v); chk("R6 level write ignored", v, 32'hCAFE_5678);
        rd(12'h10c, v); chk("R7 no notify on dir read", {31'b0, lvl_rd_pulse}, 0);
    endtask

    task automatic t_range();
        logic [31:0] v;
        logic [127:0] oe0;
        oe0 = pin_oe;
        wr(12'h20c, 32'hFFFF_FFFF);
        wr(12'h30c, 32'h0000_0000);
        chk("R8 far write no error", {31'b0, bad_addr_pulse}, 0);
        chk("R8 far write ignored", {31'b0, pin_oe != oe0}, 0);
        rd(12'h30c, v);
        chk("R8 far read zero", v, 0);
        chk("R8 far read valid no error", {30'b0, bus_rvalid, bad_addr_pulse}, 32'h2);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        logic [127:0] oe0;
        rd(12'h074, v);
        chk("R9 hole read zero", v, 0);
        chk("R9 hole read error", {30'b0, bus_rvalid, bad_addr_pulse}, 32'h3);
        rd(12'h00e, v);
        chk("R9 unaligned error", {31'b0, bad_addr_pulse}, 1);
        chk("R9 unaligned zero", v, 0);
        oe0 = pin_oe;
        wr(12'h180, 32'hFFFF_FFFF);
        chk("R9 hole write error", {31'b0, bad_addr_pulse}, 1);
        wr(12'h10d, 32'hFFFF_FFFF);
        chk("R9 hole write ignored", {31'b0, pin_oe != oe0}, 0);
        rd(12'h00c, v);
        chk("R9 error one cycle", {31'b0, bad_addr_pulse}, 0);
    endtask

    task automatic t_status();
        edge_word = 32'h1357_2468;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 12'h148;
        #1;
        chk("R10 status bank select", {30'b0, edge_sel}, 3);
        chk("R10 no clear on read", {31'b0, edge_clr}, 0);
        @(posedge clk); #1;
        bus_rd = 1'b0;
        chk("R10 status read", bus_rdata, 32'h1357_2468);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h04c; bus_wdata = 32'h0000_00F0;
        #1;
        chk("R10 clear strobe", {31'b0, edge_clr}, 1);
        chk("R10 clear mask", edge_clr_mask, 32'h0000_00F0);
        chk("R10 clear bank", {30'b0, edge_sel}, 1);
        @(posedge clk); #1;
        bus_wr = 1'b0;
        #1;
        chk("R10 clear drops", {31'b0, edge_clr}, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        cyc(1'b1, 1'b1, 12'h00c, 32'h0000_0055);
        chk("R11 read dropped", {31'b0, bus_rvalid}, 0);
        rd(12'h00c, v);
        chk("R11 write applied", v, 32'h0000_0055);
        cyc(1'b1, 1'b1, 12'h000, 32'h0);
        chk("R11 no notify", {30'b0, bus_rvalid, lvl_rd_pulse}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_map();
        t_setclr();
        t_level();
        t_range();
        t_unmapped();
        t_status();
        t_collide();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule